// File: doc/BRIEF.md
# Pin Control Register Bank

This block holds the configuration of every pad on one 32-pin I/O port. Each pin owns a 32-bit register whose low half sets the pad's pull resistor, slew rate, passive filter, open-drain mode, drive strength and function select, plus a lock bit. Bits [19:16] hold the pin's interrupt trigger configuration. The stored settings are decoded and driven out as parallel per-pin buses, which feed the pad ring and the function multiplexer elsewhere in the chip.

A simple register bus reaches the bank. The bus has a write strobe, a 6-bit word address, write data and combinational read data. Four broadcast registers let one access reach many pins at once. Two of them apply one 16-bit configuration to any subset of pins, one for the lower sixteen pins and one for the upper sixteen. The other two apply one interrupt configuration to any subset of pins, again one for each half. The lock bit protects a pin's configuration half from every kind of write until the next reset.

Top module: `pin_ctrl_bank`

## Requirements
- R1: After reset, every stored field is zero. Every output bus is all zeros, and every pin register reads back as zero.
- R2: A write to word address 0..31 updates that pin's register. Readback returns the implemented bits: [1:0], 2, 4, 5, 6, the function field [11:8] and 15, plus the interrupt field [19:16]. Bits 3, 7, [14:12] and [31:20] read as zero.
- R3: Pull field [1:0] decode: value 3 asserts pullUpEn, value 2 asserts pullDownEn, and values 0 and 1 assert neither.
- R4: Bit 2 drives slewSlow, bit 4 drives filterEn, bit 5 drives openDrainEn and bit 6 drives driveHigh. Field [11:8] drives the pin's 4-bit slice of muxSel, where 0 means disabled/analog, 1 means GPIO and 2..15 select alternate functions.
- R5: When bit 15 of a pin is set, the pin's lockSet output is 1 and writes to bits [15:0] of that pin are ignored.
- R6: A locked pin stays locked until reset. After reset its register reads zero again.
- R7: The interrupt field [19:16] is outside the lock. A direct write updates it even on a locked pin.
- R8: A write to address 32 applies data bits [15:0] to pins 0..15. It reaches every pin whose bit is set in the mask in data bits [31:16], where mask bit k selects pin k.
- R9: A write to address 33 does the same for pins 16..31, where mask bit k (data bit 16+k) selects pin 16+k.
- R10: Broadcast configuration writes (R8, R9) leave locked pins unchanged.
- R11: A write to address 34 (pins 0..15) or 35 (pins 16..31) stores data bits [19:16] into the interrupt field of each pin selected by the mask in data bits [15:0]. Locked pins are included.
- R12: Addresses 32..63 read back as zero. Addresses 36..63 have no effect when written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWe | input | 1 | Write strobe for one cycle |
| busAddr | input | 6 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| pullUpEn | output | 32 | Pull-up enable per pin |
| pullDownEn | output | 32 | Pull-down enable per pin |
| slewSlow | output | 32 | Slow slew per pin |
| filterEn | output | 32 | Passive filter enable per pin |
| openDrainEn | output | 32 | Open-drain enable per pin |
| driveHigh | output | 32 | High drive strength per pin |
| muxSel | output | 128 | 4-bit function select per pin, pin k at [4k+3:4k] |
| irqCfg | output | 128 | 4-bit interrupt configuration per pin, pin k at [4k+3:4k] |
| lockSet | output | 1 x 32 = 32 | Lock state per pin |

## Verification
A table of writes tries each path into storage. Direct writes use dense patterns, so the readback shows that reserved bits are dropped. Broadcast writes use sparse masks in both halves, so a mask bit that lands on the wrong pin shows up, and so does a half that lands on the other half's pins. Broadcast interrupt writes are followed by a readback of the whole register, which shows the interrupt field changed while the configuration half did not. Directed tests then lock a pin and hit it with direct, broadcast configuration and broadcast interrupt writes. This separates what the lock guards from what it passes. The tests also cover every pull encoding and finish with a reset that must clear a lock.

// File: rtl/pin_ctrl_pkg.sv
`timescale 1ns/1ps
package pin_ctrl_pkg;
  localparam int PIN_IDX_W = 5;
  localparam int ADDR_W    = 6;
  localparam int DATA_W    = 32;
  localparam int HALF      = 16;

  // decoded write request handed from control to datapath
  typedef struct packed {
    logic                 pinWr;
    logic                 cfgLo;
    logic                 cfgHi;
    logic                 irqLo;
    logic                 irqHi;
    logic [PIN_IDX_W-1:0] pinIdx;
  } pcbStrobe_t;
endpackage

// File: rtl/pin_ctrl_decode.sv
`timescale 1ns/1ps
module pin_ctrl_decode
  import pin_ctrl_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output pcbStrobe_t        strobe
);
  localparam logic [ADDR_W-1:0] PIN_LIMIT = ADDR_W'(NPINS);
  localparam logic [ADDR_W-1:0] A_CFG_LO  = ADDR_W'(32);
  localparam logic [ADDR_W-1:0] A_CFG_HI  = ADDR_W'(33);
  localparam logic [ADDR_W-1:0] A_IRQ_LO  = ADDR_W'(34);
  localparam logic [ADDR_W-1:0] A_IRQ_HI  = ADDR_W'(35);

  always_comb begin
    strobe        = '0;
    strobe.pinIdx = busAddr[PIN_IDX_W-1:0];
    if (busWe) begin
      strobe.pinWr = (busAddr < PIN_LIMIT);
      strobe.cfgLo = (busAddr == A_CFG_LO);
      strobe.cfgHi = (busAddr == A_CFG_HI);
      strobe.irqLo = (busAddr == A_IRQ_LO);
      strobe.irqHi = (busAddr == A_IRQ_HI);
    end
  end

  // R8 R9 R11 R12: one access is at most one kind of write
  single_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.pinWr, strobe.cfgLo, strobe.cfgHi, strobe.irqLo, strobe.irqHi}));

  // R12: no request without a bus write
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busWe |-> !(strobe.pinWr || strobe.cfgLo || strobe.cfgHi || strobe.irqLo || strobe.irqHi));
endmodule

// File: rtl/pin_ctrl_store.sv
`timescale 1ns/1ps
module pin_ctrl_store
  import pin_ctrl_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int MUX_W = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  pcbStrobe_t              strobe,
  input  logic [DATA_W-1:0]       busWdata,
  input  logic [ADDR_W-1:0]       busAddr,
  output logic [DATA_W-1:0]       busRdata,
  output logic [NPINS-1:0]        pullUpEn,
  output logic [NPINS-1:0]        pullDownEn,
  output logic [NPINS-1:0]        slewSlow,
  output logic [NPINS-1:0]        filterEn,
  output logic [NPINS-1:0]        openDrainEn,
  output logic [NPINS-1:0]        driveHigh,
  output logic [MUX_W*NPINS-1:0]  muxSel,
  output logic [4*NPINS-1:0]      irqCfg,
  output logic [NPINS-1:0]        lockSet
);
  localparam logic [15:0] MUX_BITS  = 16'(((1 << MUX_W) - 1) << 8);
  localparam logic [15:0] CFG_MASK  = 16'h8077 | MUX_BITS;
  localparam logic [ADDR_W-1:0] PIN_LIMIT = ADDR_W'(NPINS);
  localparam int LOCK_BIT = 15;

  logic [15:0] cfgQ [NPINS];
  logic [3:0]  irqQ [NPINS];
  logic [NPINS-1:0] cfgEn;
  logic [NPINS-1:0] irqEn;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    localparam bit IS_LO = (i < HALF);
    localparam int SUB   = i % HALF;
    logic direct, grpCfg, grpIrq;

    assign direct = strobe.pinWr && (strobe.pinIdx == PIN_IDX_W'(i));
    assign grpCfg = (IS_LO ? strobe.cfgLo : strobe.cfgHi) && busWdata[HALF + SUB];
    assign grpIrq = (IS_LO ? strobe.irqLo : strobe.irqHi) && busWdata[SUB];
    assign cfgEn[i] = (direct || grpCfg) && !cfgQ[i][LOCK_BIT];
    assign irqEn[i] = direct || grpIrq;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfgQ[i] <= '0;
        irqQ[i] <= '0;
      end else begin
        if (cfgEn[i]) cfgQ[i] <= busWdata[15:0] & CFG_MASK;
        if (irqEn[i]) irqQ[i] <= busWdata[19:16];
      end
    end

    assign pullUpEn[i]    = (cfgQ[i][1:0] == 2'd3);
    assign pullDownEn[i]  = (cfgQ[i][1:0] == 2'd2);
    assign slewSlow[i]    = cfgQ[i][2];
    assign filterEn[i]    = cfgQ[i][4];
    assign openDrainEn[i] = cfgQ[i][5];
    assign driveHigh[i]   = cfgQ[i][6];
    assign muxSel[i*MUX_W +: MUX_W] = cfgQ[i][8 +: MUX_W];
    assign irqCfg[i*4 +: 4] = irqQ[i];
    assign lockSet[i]     = cfgQ[i][LOCK_BIT];

    // R5 R10: a locked configuration half never moves
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      cfgQ[i][LOCK_BIT] |=> $stable(cfgQ[i]));

    // R6: lock is sticky until reset
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
      lockSet[i] |=> lockSet[i]);

    // R11: interrupt field changes only on a request for this pin
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
      !irqEn[i] |=> $stable(irqQ[i]));
  end

  always_comb begin
    busRdata = '0;
    if (busAddr < PIN_LIMIT)
      busRdata = {12'b0, irqQ[busAddr[PIN_IDX_W-1:0]], cfgQ[busAddr[PIN_IDX_W-1:0]]};
  end

  // R2: reserved bits never read as one
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRdata[31:20] == '0) && (busRdata[15:0] & ~CFG_MASK) == '0);
endmodule

// File: rtl/pin_ctrl_bank.sv
`timescale 1ns/1ps
module pin_ctrl_bank
  import pin_ctrl_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int MUX_W = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busWe,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [DATA_W-1:0]      busWdata,
  output logic [DATA_W-1:0]      busRdata,
  output logic [NPINS-1:0]       pullUpEn,
  output logic [NPINS-1:0]       pullDownEn,
  output logic [NPINS-1:0]       slewSlow,
  output logic [NPINS-1:0]       filterEn,
  output logic [NPINS-1:0]       openDrainEn,
  output logic [NPINS-1:0]       driveHigh,
  output logic [MUX_W*NPINS-1:0] muxSel,
  output logic [4*NPINS-1:0]     irqCfg,
  output logic [NPINS-1:0]       lockSet
);
  pcbStrobe_t strobe;

  pin_ctrl_decode #(.NPINS(NPINS)) u_decode (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .strobe(strobe)
  );

  pin_ctrl_store #(.NPINS(NPINS), .MUX_W(MUX_W)) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata), .busAddr(busAddr),
    .busRdata(busRdata), .pullUpEn(pullUpEn), .pullDownEn(pullDownEn),
    .slewSlow(slewSlow), .filterEn(filterEn), .openDrainEn(openDrainEn),
    .driveHigh(driveHigh), .muxSel(muxSel), .irqCfg(irqCfg), .lockSet(lockSet)
  );
endmodule

// File: tb/tb_pin_ctrl_bank.sv
`timescale 1ns/1ps
module tb_pin_ctrl_bank;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busWe = 1'b0;
  logic [5:0]   busAddr = '0;
  logic [31:0]  busWdata = '0;
  logic [31:0]  busRdata;
  logic [31:0]  pullUpEn, pullDownEn, slewSlow, filterEn, openDrainEn, driveHigh, lockSet;
  logic [127:0] muxSel, irqCfg;

  int checks = 0;
  int errors = 0;

  pin_ctrl_bank dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .pullUpEn(pullUpEn), .pullDownEn(pullDownEn),
    .slewSlow(slewSlow), .filterEn(filterEn), .openDrainEn(openDrainEn),
    .driveHigh(driveHigh), .muxSel(muxSel), .irqCfg(irqCfg), .lockSet(lockSet)
  );

  always #5 clk = ~clk;

  typedef struct packed {
    logic        we;
    logic [5:0]  wa;
    logic [31:0] wd;
    logic [5:0]  ra;
    logic [31:0] ex;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 6'd3,  32'hFFF5_7F7B, 6'd3,  32'h0005_0F73},  // R2 dense write, reserved dropped
    '{1'b1, 6'd5,  32'h0000_0A56, 6'd5,  32'h0000_0A56},  // R2
    '{1'b1, 6'd32, 32'h0021_0102, 6'd5,  32'h0000_0102},  // R8 mask pins 0,5
    '{1'b0, 6'd0,  32'h0,         6'd0,  32'h0000_0102},  // R8
    '{1'b1, 6'd33, 32'h8001_0203, 6'd31, 32'h0000_0203},  // R9 mask pins 16,31
    '{1'b0, 6'd0,  32'h0,         6'd16, 32'h0000_0203},  // R9
    '{1'b1, 6'd34, 32'h000A_0028, 6'd3,  32'h000A_0F73},  // R11 pins 3,5
    '{1'b1, 6'd35, 32'h0007_0001, 6'd16, 32'h0007_0203},  // R11 pin 16
    '{1'b0, 6'd0,  32'h0,         6'd32, 32'h0000_0000},  // R12 broadcast reads zero
    '{1'b1, 6'd40, 32'hFFFF_FFFF, 6'd17, 32'h0000_0000}   // R12 unmapped write ignored
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(6'd7, r);
    check("R1 readback", r, 32'h0);
    check("R1 pulls", pullUpEn | pullDownEn, 32'h0);
    check("R1 mux", muxSel[31:0] | muxSel[127:96], 32'h0);
    check("R1 lock", lockSet, 32'h0);

    for (int k = 0; k < NVEC; k++) begin
      if (VEC[k].we) wr(VEC[k].wa, VEC[k].wd);
      else @(negedge clk);
      rd(VEC[k].ra, r);
      check($sformatf("R2/R8/R9/R11/R12 vec%0d", k), r, VEC[k].ex);
    end

    // R3 pull decode
    check("R3 pin3 up", {30'b0, pullUpEn[3], pullDownEn[3]}, 32'h2);
    check("R3 pin5 down", {30'b0, pullUpEn[5], pullDownEn[5]}, 32'h1);
    // R4 field decode on pin 3 (0x0F73)
    check("R4 pin3 flags", {28'b0, slewSlow[3], filterEn[3], openDrainEn[3], driveHigh[3]}, 32'h7);
    check("R4 pin3 mux", {28'b0, muxSel[12 +: 4]}, 32'hF);
    check("R4 pin16 mux", {28'b0, muxSel[64 +: 4]}, 32'h2);
    check("R11 pin16 irq out", {28'b0, irqCfg[64 +: 4]}, 32'h7);
    wr(6'd9, 32'h0000_0005);
    check("R3 value1 no pull", {30'b0, pullUpEn[9], pullDownEn[9]}, 32'h0);
    check("R4 pin9 slow", {31'b0, slewSlow[9]}, 32'h1);
    wr(6'd9, 32'h0000_0000);
    check("R3 value0 no pull", {30'b0, pullUpEn[9], pullDownEn[9]}, 32'h0);

    // R5 lock, R7 irq bypass
    wr(6'd10, 32'h0000_8304);
    check("R5 lockSet", {31'b0, lockSet[10]}, 32'h1);
    wr(6'd10, 32'h000B_0000);
    rd(6'd10, r);
    check("R5 R7 locked direct write", r, 32'h000B_8304);
    // R10 broadcast skips locked pin 10, updates pin 11
    wr(6'd32, 32'h0C00_0011);
    rd(6'd10, r);
    check("R10 locked pin kept", r, 32'h000B_8304);
    rd(6'd11, r);
    check("R10 unlocked neighbour", r, 32'h0000_0011);
    // R11 broadcast irq reaches locked pin
    wr(6'd34, 32'h0003_0400);
    rd(6'd10, r);
    check("R11 irq on locked pin", r, 32'h0003_8304);
    rd(6'd33, r);
    check("R12 broadcast reads zero", r, 32'h0);

    // R6 reset clears lock
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R6 lock cleared", lockSet, 32'h0);
    rd(6'd10, r);
    check("R6 readback after reset", r, 32'h0);
    wr(6'd10, 32'h0000_0003);
    rd(6'd10, r);
    check("R6 writable again", r, 32'h0000_0003);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule